// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block is the next-address logic of an in-order core whose control transfers have one delay slot. It keeps two address registers. The first is the address of the instruction now being presented. The second is the address that follows it. A control transfer does not redirect the current instruction. It redirects the following address. The instruction already lined up behind the branch, the delay slot, therefore still runs unless the branch asks for it to be annulled.

The core pulses a retire strobe once per finished instruction. With that strobe it supplies three things: whether the retiring instruction is a control transfer, whether that transfer is taken together with its target, and whether the branch requests annulment. The sequencer answers with the address of the next instruction and a suppress flag. The suppress flag tells the pipeline to discard that instruction's effects. A taken annulled branch still presents its delay slot, but marked as suppressed. An untaken annulled branch skips the slot entirely by jumping two words past itself. A control transfer found inside a delay slot is not supported. It raises a sticky error flag, and sequencing carries on as if the instruction were not a branch.

Top module: `dslot_seq`

## Requirements
- R1: After reset, pc_o is 0, npc_o is 4, suppress_o is 0 and nest_err_o is 0.
- R2: In a cycle with retire_i low, pc_o, npc_o, suppress_o and nest_err_o keep their values, whatever the other inputs carry.
- R3: A retired instruction that is not a control transfer moves the old npc_o into pc_o and sets npc_o to the old npc_o plus 4, with suppress_o low afterwards.
- R4: A retired taken transfer without annul moves the old npc_o (the delay slot) into pc_o. It loads npc_o with target_i with bits [1:0] forced to 0, and leaves suppress_o low. The retirement of the slot then moves pc_o to that target.
- R5: A retired taken transfer with annul_i high presents the delay slot in pc_o with suppress_o high. The next retirement lowers suppress_o and moves pc_o to the masked target.
- R6: A retired untaken transfer with annul_i high sets pc_o to the branch's pc_o plus 8 and npc_o to that pc_o plus 12, with suppress_o low.
- R7: A retired untaken transfer without annul behaves like R3: the delay slot runs unsuppressed and sequencing continues after it.
- R8: While suppress_o is high, a retirement ignores cti_i, taken_i, annul_i and target_i. It advances exactly as in R3, and it never sets nest_err_o.
- R9: A control transfer retired in an unsuppressed delay slot sets nest_err_o, which stays high until reset. That retirement advances the addresses as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retires this cycle |
| cti_i | input | 1 | The retiring instruction is a control transfer |
| taken_i | input | 1 | The control transfer is taken |
| annul_i | input | 1 | The control transfer requests annulment of its delay slot |
| target_i | input | AW | Branch target address |
| pc_o | output | AW | Address of the instruction now presented |
| npc_o | output | AW | Address that follows pc_o |
| suppress_o | output | 1 | The instruction at pc_o must be discarded |
| nest_err_o | output | 1 | Sticky flag: a control transfer appeared in a delay slot |

## Verification
Corrupted address state shows on pc_o or npc_o in the very cycle after the retirement that computes it. A lost or stuck annul flag shows one retirement later. It appears either as suppress_o held across two instructions or as a slot that runs when it should not. A wrong delay-slot marker stays hidden until a second branch arrives. Such a branch then either raises nest_err_o when it should not, or takes effect when it should have faulted. The sequences therefore place branches both directly after other branches and after plain instructions.

// File: rtl/dslot_seq_pkg.sv
package dslot_seq_pkg;
  // Action chosen for one cycle; decides how the address pair moves.
  typedef enum logic [2:0] {
    STEP_HOLD      = 3'd0,  // nothing retired
    STEP_SEQ       = 3'd1,  // plain sequential advance
    STEP_FALL      = 3'd2,  // untaken branch: next instruction is a live slot
    STEP_JUMP      = 3'd3,  // taken branch, slot runs
    STEP_JUMP_SKIP = 3'd4,  // taken branch, slot suppressed
    STEP_SKIP2     = 3'd5,  // untaken annulled branch, slot skipped
    STEP_FAULT     = 3'd6   // branch inside a delay slot
  } step_e;
endpackage

// File: rtl/dslot_seq_ctl.sv
module dslot_seq_ctl
  import dslot_seq_pkg::*;
(
  input  logic  retire,
  input  logic  is_cti,
  input  logic  taken,
  input  logic  annul,
  input  logic  sup_q,
  input  logic  slot_q,
  output step_e step
);
  always_comb begin
    if (!retire)              step = STEP_HOLD;
    else if (sup_q)           step = STEP_SEQ;
    else if (!is_cti)         step = STEP_SEQ;
    else if (slot_q)          step = STEP_FAULT;
    else if (taken && annul)  step = STEP_JUMP_SKIP;
    else if (taken)           step = STEP_JUMP;
    else if (annul)           step = STEP_SKIP2;
    else                      step = STEP_FALL;
  end
endmodule

// File: rtl/dslot_seq_next.sv
module dslot_seq_next
  import dslot_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input  step_e         step,
  input  logic [AW-1:0] pc_q,
  input  logic [AW-1:0] npc_q,
  input  logic [AW-1:0] target,
  input  logic          sup_q,
  input  logic          slot_q,
  output logic [AW-1:0] pc_n,
  output logic [AW-1:0] npc_n,
  output logic          sup_n,
  output logic          slot_n
);
  localparam logic [AW-1:0] WORD  = AW'(INSN_BYTES);
  localparam logic [AW-1:0] TWO   = AW'(2 * INSN_BYTES);
  localparam logic [AW-1:0] THREE = AW'(3 * INSN_BYTES);
  localparam logic [AW-1:0] MASK  = ~AW'(INSN_BYTES - 1);

  logic [AW-1:0] tgt_al;
  logic [AW-1:0] npc_inc;
  assign tgt_al  = target & MASK;
  assign npc_inc = npc_q + WORD;

  always_comb begin
    pc_n   = pc_q;
    npc_n  = npc_q;
    sup_n  = sup_q;
    slot_n = slot_q;
    unique case (step)
      STEP_HOLD: ;
      STEP_SEQ, STEP_FAULT: begin
        pc_n = npc_q; npc_n = npc_inc; sup_n = 1'b0; slot_n = 1'b0;
      end
      STEP_FALL: begin
        pc_n = npc_q; npc_n = npc_inc; sup_n = 1'b0; slot_n = 1'b1;
      end
      STEP_JUMP: begin
        pc_n = npc_q; npc_n = tgt_al; sup_n = 1'b0; slot_n = 1'b1;
      end
      STEP_JUMP_SKIP: begin
        pc_n = npc_q; npc_n = tgt_al; sup_n = 1'b1; slot_n = 1'b1;
      end
      STEP_SKIP2: begin
        pc_n = pc_q + TWO; npc_n = pc_q + THREE; sup_n = 1'b0; slot_n = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dslot_seq.sv
module dslot_seq
  import dslot_seq_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            INSN_BYTES = 4,
  parameter logic [AW-1:0] RESET_PC   = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retire_i,
  input  logic          cti_i,
  input  logic          taken_i,
  input  logic          annul_i,
  input  logic [AW-1:0] target_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic          suppress_o,
  output logic          nest_err_o
);
  localparam logic [AW-1:0] RESET_NPC = RESET_PC + AW'(INSN_BYTES);

  logic [AW-1:0] pc_q, npc_q, pc_n, npc_n;
  logic          sup_q, sup_n, slot_q, slot_n, err_q;
  step_e         step;

  dslot_seq_ctl u_ctl (
    .retire (retire_i),
    .is_cti (cti_i),
    .taken  (taken_i),
    .annul  (annul_i),
    .sup_q  (sup_q),
    .slot_q (slot_q),
    .step   (step)
  );

  dslot_seq_next #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_next (
    .step   (step),
    .pc_q   (pc_q),
    .npc_q  (npc_q),
    .target (target_i),
    .sup_q  (sup_q),
    .slot_q (slot_q),
    .pc_n   (pc_n),
    .npc_n  (npc_n),
    .sup_n  (sup_n),
    .slot_n (slot_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      npc_q  <= RESET_NPC;
      sup_q  <= 1'b0;
      slot_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pc_q   <= pc_n;
      npc_q  <= npc_n;
      sup_q  <= sup_n;
      slot_q <= slot_n;
      err_q  <= err_q | (step == STEP_FAULT);
    end
  end

  assign pc_o       = pc_q;
  assign npc_o      = npc_q;
  assign suppress_o = sup_q;
  assign nest_err_o = err_q;
endmodule

// File: rtl/dslot_seq_chk.sv
module dslot_seq_chk #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          retire_i,
  input logic          cti_i,
  input logic          taken_i,
  input logic          annul_i,
  input logic [AW-1:0] target_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] npc_o,
  input logic          suppress_o,
  input logic          nest_err_o,
  input logic          slot_q
);
  localparam logic [AW-1:0] MASK = ~AW'(INSN_BYTES - 1);

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !retire_i |=> $stable(pc_o) && $stable(npc_o) && $stable(suppress_o) && $stable(nest_err_o));

  // R3
  seq_adv_chk: assert property (@(posedge clk) disable iff (rst)
    retire_i && (!cti_i || suppress_o || (!taken_i && !annul_i))
    |=> pc_o == $past(npc_o) && npc_o == $past(npc_o) + AW'(INSN_BYTES));

  // R4
  taken_load_chk: assert property (@(posedge clk) disable iff (rst)
    retire_i && cti_i && taken_i && !suppress_o && !slot_q
    |=> pc_o == $past(npc_o) && npc_o == ($past(target_i) & MASK));

  // R5
  annul_set_chk: assert property (@(posedge clk) disable iff (rst)
    retire_i && cti_i && taken_i && annul_i && !suppress_o && !slot_q |=> suppress_o);

  // R5
  annul_clear_chk: assert property (@(posedge clk) disable iff (rst)
    retire_i && suppress_o |=> !suppress_o);

  // R6
  skip_two_chk: assert property (@(posedge clk) disable iff (rst)
    retire_i && cti_i && !taken_i && annul_i && !suppress_o && !slot_q
    |=> pc_o == $past(pc_o) + AW'(2 * INSN_BYTES) && !suppress_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    nest_err_o |=> nest_err_o);

  // R8
  sup_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !nest_err_o && suppress_o |=> !nest_err_o);
endmodule

bind dslot_seq dslot_seq_chk #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .retire_i   (retire_i),
  .cti_i      (cti_i),
  .taken_i    (taken_i),
  .annul_i    (annul_i),
  .target_i   (target_i),
  .pc_o       (pc_o),
  .npc_o      (npc_o),
  .suppress_o (suppress_o),
  .nest_err_o (nest_err_o),
  .slot_q     (slot_q)
);

// File: tb/dslot_seq_bench.sv
module dslot_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_i = 1'b0, cti_i = 1'b0, taken_i = 1'b0, annul_i = 1'b0;
  logic [31:0] target_i = '0;
  logic [31:0] pc_o, npc_o;
  logic        suppress_o, nest_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [31:0] m_pc, m_npc;
  bit          m_sup, m_slot, m_err;

  always #2 clk = ~clk;

  dslot_seq u_dslot_seq (
    .clk(clk), .rst(rst), .retire_i(retire_i), .cti_i(cti_i), .taken_i(taken_i),
    .annul_i(annul_i), .target_i(target_i), .pc_o(pc_o), .npc_o(npc_o),
    .suppress_o(suppress_o), .nest_err_o(nest_err_o)
  );

  task automatic model_reset();
    m_pc = 32'd0; m_npc = 32'd4; m_sup = 0; m_slot = 0; m_err = 0;
  endtask

  task automatic model_step(bit r, bit c, bit t, bit a, logic [31:0] tg);
    logic [31:0] old_pc, old_npc;
    old_pc = m_pc; old_npc = m_npc;
    if (!r) return;
    if (m_sup || !c) begin
      m_pc = old_npc; m_npc = old_npc + 4; m_sup = 0; m_slot = 0;
    end else if (m_slot) begin
      m_err = 1; m_pc = old_npc; m_npc = old_npc + 4; m_slot = 0;
    end else if (t) begin
      m_pc = old_npc; m_npc = {tg[31:2], 2'b00}; m_slot = 1; m_sup = a;
    end else if (a) begin
      m_pc = old_pc + 8; m_npc = old_pc + 12; m_slot = 0;
    end else begin
      m_pc = old_npc; m_npc = old_npc + 4; m_slot = 1;
    end
  endtask

  task automatic compare(string req);
    checks++;
    if (pc_o !== m_pc || npc_o !== m_npc || suppress_o !== m_sup || nest_err_o !== m_err) begin
      fails++;
      $display("FAIL %s actual pc=%h npc=%h sup=%b err=%b expected pc=%h npc=%h sup=%b err=%b",
               req, pc_o, npc_o, suppress_o, nest_err_o, m_pc, m_npc, m_sup, m_err);
    end
  endtask

  // drive at negedge, model the edge, compare at the following negedge
  task automatic step(string req, bit r, bit c, bit t, bit a, logic [31:0] tg);
    retire_i = r; cti_i = c; taken_i = t; annul_i = a; target_i = tg;
    model_step(r, c, t, a, tg);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    retire_i = 0; cti_i = 0; taken_i = 0; annul_i = 0; target_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    compare("R1");
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R2: idle cycles with noise on the other inputs
    step("R2", 0, 1, 1, 1, 32'h0000_0ABC);
    step("R2", 0, 1, 0, 1, 32'h1234_5678);

    // R3: plain sequencing
    for (int i = 0; i < 4; i++) step("R3", 1, 0, 1, 1, 32'hFFFF_FFF0);

    // R4: taken branch, slot runs, then target (low bits dropped)
    step("R4", 1, 1, 1, 0, 32'h0000_0103);
    step("R4", 1, 0, 0, 0, 32'h0);
    step("R4", 1, 0, 0, 0, 32'h0);

    // R5 and R8: taken annulled branch, suppressed slot carries branch noise
    step("R5", 1, 1, 1, 1, 32'h0000_0402);
    step("R8", 1, 1, 1, 0, 32'h0000_0800);
    step("R5", 1, 0, 0, 0, 32'h0);

    // R6: untaken annulled branch skips two words
    step("R6", 1, 1, 0, 1, 32'h0000_0900);
    step("R6", 1, 0, 0, 0, 32'h0);

    // R7: untaken plain branch, slot runs
    step("R7", 1, 1, 0, 0, 32'h0000_0A00);
    step("R7", 1, 0, 0, 0, 32'h0);

    // R2: idle in the middle of a delay slot
    step("R4", 1, 1, 1, 0, 32'h0000_2000);
    step("R2", 0, 1, 1, 0, 32'h0000_3000);
    step("R4", 1, 0, 0, 0, 32'h0);

    // R9: branch inside a live slot
    step("R9", 1, 1, 1, 0, 32'h0000_4000);
    step("R9", 1, 1, 1, 1, 32'h0000_5000);
    step("R9", 1, 0, 0, 0, 32'h0);
    step("R9", 0, 0, 0, 0, 32'h0);
    do_reset();

    // R8: suppressed slot holding an untaken-annul pattern must not skip
    step("R5", 1, 1, 1, 1, 32'h0000_6000);
    step("R8", 1, 1, 0, 1, 32'h0000_7000);

    // mixed random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] tg;
      tg = $urandom;
      step("R3", ($urandom % 4) != 0, ($urandom % 3) == 0, $urandom % 2, $urandom % 2, tg);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule